// File: doc/BRIEF.md
# Wake and Kickstart Power Sequencer

This controller decides when a system asks for its main supply and when it raises an interrupt. Two sources can start a power-on. The first is a kickstart button input that is active low and must stay low for a minimum number of cycles before it counts. The second is a one-cycle wake strobe that comes from an external time-of-day alarm compare. When one of these sources fires with its enable bit set, the block asserts an open-drain power request. It then waits a bounded number of cycles for the supply to report good. On success it keeps the request on and clears the power-down bit. If the supply does not arrive in time, it releases the request again. The flag that named the cause stays set in either case.

Software controls the block through one 5-bit control register. The register holds the two cause flags, the two enables and the power-down bit. Software clears a flag by writing 0 to it. Writing 1 to the power-down bit while powered releases the request. The interrupt output is active low and has its own drive enable. It is driven only while the supply is above the power-fail level. It reports an enabled cause flag or an external pending interrupt. All inputs except the kickstart pin are assumed synchronous to the clock. The kickstart pin passes through a synchronizer.

Top module: `wkpwr_seq`

## Requirements
- R1: After reset, `pwr_req_en_o` is 0. `reg_rdata_o` reads 5'b10000: the power-down bit (bit 4) is 1, and the kick enable (bit 3), wake enable (bit 2), kick flag (bit 1) and wake flag (bit 0) are all 0.
- R2: A low level on `kick_n_i` that lasts `KICK_MIN_CYC` cycles or longer produces exactly one kick event. A low level of `KICK_MIN_CYC-1` cycles or fewer is ignored: it changes no register bit and does not touch the power request.
- R3: While the block is powered down, an enabled kick event sets the kick flag and a wake strobe with the wake enable set sets the wake flag. Either one makes `pwr_req_en_o` go to 1 on the next cycle. With the matching enable at 0 and the supply not good, the event is ignored.
- R4: If `supply_good_i` stays low for `PWRON_TMO_CYC` cycles after the request is asserted, `pwr_req_en_o` returns to 0. The cause flag stays set until software writes 0 to it.
- R5: If `supply_good_i` is seen high during the wait, the request stays at 1 and the power-down bit is cleared to 0 on the next cycle.
- R6: While powered, a register write with bit 4 = 1 makes `pwr_req_en_o` 0 on the next cycle.
- R7: A register write of 0 to a flag bit clears that flag. A write of 1 to a flag bit leaves it unchanged. Enable bits and the power-down bit take the written value. An event in the same cycle as a clearing write wins.
- R8: `irq_n_o` is 0 exactly when (wake flag AND wake enable) OR (kick flag AND kick enable) OR `ext_irq_pend_i`.
- R9: `irq_oe_o` equals `above_pf_i`. The interrupt pin is released whenever the supply is below the power-fail level.
- R10: With the supply good and the request released, an enabled kick or wake event asserts the request again and clears the power-down bit.
- R11: While `supply_good_i` is 1, kick and wake events set their flags even when the enables are 0. The interrupt output still respects the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| kick_n_i | input | 1 | Kickstart button, active low, asynchronous |
| wake_match_i | input | 1 | One-cycle strobe from the alarm compare |
| supply_good_i | input | 1 | Main supply above both the battery level and the power-fail level |
| above_pf_i | input | 1 | Main supply above the power-fail level |
| ext_irq_pend_i | input | 1 | Another interrupt source is pending |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 5 | Write data {pdown, kick_en, wake_en, kick_flag, wake_flag} |
| reg_rdata_o | output | 5 | Control register contents, same layout |
| pwr_req_en_o | output | 1 | 1 = pull the open-drain power request low |
| irq_n_o | output | 1 | Interrupt level, active low |
| irq_oe_o | output | 1 | Interrupt drive enable; 0 = high impedance |

## Verification
Kick pulses of exactly `KICK_MIN_CYC` and `KICK_MIN_CYC-1` cycles show whether the filter has the right threshold. Wake strobes are sent with the enable clear and set, and with the supply absent and present. This separates the powered-down gating of events from the always-set flag behaviour while powered. One power-on attempt never sees the supply and one sees it in time. Together they separate the timeout release, the sticky flag and the automatic clear of the power-down bit. A long random phase of writes, wake strobes and external interrupts follows, checked against a bench model. It covers the write-0-to-clear rule, set-wins-over-clear, and the interrupt equation for every mix of flags and enables.

// File: rtl/wkpwr_pkg.sv
package wkpwr_pkg;

    // Control register layout, MSB first: {pdown, kick_en, wake_en, kick_flag, wake_flag}
    typedef struct packed {
        logic pdown;
        logic kick_en;
        logic wake_en;
        logic kick_flag;
        logic wake_flag;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{pdown: 1'b1, kick_en: 1'b0, wake_en: 1'b0,
                                     kick_flag: 1'b0, wake_flag: 1'b0};

    typedef enum logic [1:0] {
        PS_POWERED_DOWN = 2'd0,
        PS_WAIT_SUPPLY  = 2'd1,
        PS_POWERED      = 2'd2,
        PS_RELEASING    = 2'd3
    } pstate_t;

    // Interrupt cause, active high
    function automatic logic irq_cause(input ctrl_t c, input logic ext);
        return (c.wake_flag & c.wake_en) | (c.kick_flag & c.kick_en) | ext;
    endfunction

    // A clearing write keeps a flag only where the written bit is 1; a new event sets it
    function automatic logic flag_next(input logic cur, input logic wr, input logic wbit,
                                       input logic set);
        return (wr ? (cur & wbit) : cur) | set;
    endfunction

endpackage

// File: rtl/wkpwr_kick_filter.sv
module wkpwr_kick_filter #(
    parameter int KICK_MIN_CYC = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_n_i,
    output logic kick_evt_o
);
    localparam int CNT_W = $clog2(KICK_MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KICK_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(KICK_MIN_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt_q;
    logic                   kick_low;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= kick_n_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], kick_n_i};
            end
        end
    endgenerate

    assign kick_low = ~sync_q[SYNC_STAGES-1];

    // Counts low cycles already seen; saturates one past the threshold so it fires once
    always_ff @(posedge clk) begin
        if (rst || !kick_low)       low_cnt_q <= '0;
        else if (low_cnt_q != CNT_SAT) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign kick_evt_o = kick_low && (low_cnt_q == CNT_LAST);

endmodule

// File: rtl/wkpwr_regs.sv
module wkpwr_regs
    import wkpwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              set_wake_i,
    input  logic              set_kick_i,
    input  logic              clr_pdown_i,
    output ctrl_t             ctrl_o
);
    ctrl_t q, d, w;

    assign w = ctrl_t'(wdata_i);

    always_comb begin
        d           = q;
        d.wake_flag = flag_next(q.wake_flag, wr_i, w.wake_flag, set_wake_i);
        d.kick_flag = flag_next(q.kick_flag, wr_i, w.kick_flag, set_kick_i);
        if (wr_i) begin
            d.wake_en = w.wake_en;
            d.kick_en = w.kick_en;
            d.pdown   = w.pdown;
        end
        if (clr_pdown_i) d.pdown = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= CTRL_RESET;
        else     q <= d;
    end

    assign ctrl_o = q;

endmodule

// File: rtl/wkpwr_fsm.sv
module wkpwr_fsm
    import wkpwr_pkg::*;
#(
    parameter int PWRON_TMO_CYC = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    supply_good_i,
    input  logic    pdown_wr_i,
    output pstate_t state_o,
    output logic    clr_pdown_o,
    output logic    pwr_req_o
);
    localparam int TMO_W = $clog2(PWRON_TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(PWRON_TMO_CYC - 1);

    pstate_t          st_q, st_d;
    logic [TMO_W-1:0] tmo_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_POWERED_DOWN: if (start_i) st_d = PS_WAIT_SUPPLY;
            PS_WAIT_SUPPLY: begin
                if (supply_good_i)          st_d = PS_POWERED;
                else if (tmo_q == TMO_LAST) st_d = PS_POWERED_DOWN;
            end
            PS_POWERED:   if (pdown_wr_i) st_d = PS_RELEASING;
            PS_RELEASING: begin
                if (start_i)             st_d = PS_WAIT_SUPPLY;
                else if (!supply_good_i) st_d = PS_POWERED_DOWN;
            end
            default: st_d = PS_POWERED_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_POWERED_DOWN;
            tmo_q <= '0;
        end else begin
            st_q  <= st_d;
            tmo_q <= (st_q == PS_WAIT_SUPPLY) ? tmo_q + 1'b1 : '0;
        end
    end

    assign state_o     = st_q;
    assign clr_pdown_o = (st_q == PS_WAIT_SUPPLY) && supply_good_i;
    assign pwr_req_o   = (st_q == PS_WAIT_SUPPLY) || (st_q == PS_POWERED);

endmodule

// File: rtl/wkpwr_seq.sv
module wkpwr_seq
    import wkpwr_pkg::*;
#(
    parameter int KICK_MIN_CYC  = 8,
    parameter int PWRON_TMO_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick_n_i,
    input  logic              wake_match_i,
    input  logic              supply_good_i,
    input  logic              above_pf_i,
    input  logic              ext_irq_pend_i,
    input  logic              reg_wr_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    output logic              pwr_req_en_o,
    output logic              irq_n_o,
    output logic              irq_oe_o
);
    ctrl_t   ctrl;
    ctrl_t   wr_fields;
    pstate_t fsm_state;
    logic    kick_evt, start, clr_pdown, pdown_wr;
    logic    set_wake, set_kick;

    assign wr_fields = ctrl_t'(reg_wdata_i);

    wkpwr_kick_filter #(.KICK_MIN_CYC(KICK_MIN_CYC), .SYNC_STAGES(2)) u_kick (
        .clk        (clk),
        .rst        (rst),
        .kick_n_i   (kick_n_i),
        .kick_evt_o (kick_evt)
    );

    // Powered: every event is recorded; unpowered: only enabled ones
    assign set_kick = kick_evt     & (ctrl.kick_en | supply_good_i);
    assign set_wake = wake_match_i & (ctrl.wake_en | supply_good_i);
    assign start    = (kick_evt & ctrl.kick_en) | (wake_match_i & ctrl.wake_en);
    assign pdown_wr = reg_wr_i & wr_fields.pdown;

    wkpwr_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (reg_wr_i),
        .wdata_i     (reg_wdata_i),
        .set_wake_i  (set_wake),
        .set_kick_i  (set_kick),
        .clr_pdown_i (clr_pdown),
        .ctrl_o      (ctrl)
    );

    wkpwr_fsm #(.PWRON_TMO_CYC(PWRON_TMO_CYC)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .supply_good_i (supply_good_i),
        .pdown_wr_i    (pdown_wr),
        .state_o       (fsm_state),
        .clr_pdown_o   (clr_pdown),
        .pwr_req_o     (pwr_req_en_o)
    );

    assign reg_rdata_o = ctrl;
    assign irq_n_o     = ~irq_cause(ctrl, ext_irq_pend_i);
    assign irq_oe_o    = above_pf_i;

endmodule

// File: rtl/wkpwr_seq_chk.sv
module wkpwr_seq_chk
    import wkpwr_pkg::*;
#(
    parameter int PWRON_TMO_CYC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_i,
    input logic [CTRL_W-1:0] reg_wdata_i,
    input logic [CTRL_W-1:0] reg_rdata_o,
    input logic              supply_good_i,
    input logic              pwr_req_en_o,
    input pstate_t           fsm_state,
    input logic              kick_evt
);
    localparam int WIN_W = $clog2(PWRON_TMO_CYC + 2);

    logic [WIN_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst)                               wait_cnt <= '0;
        else if (fsm_state == PS_WAIT_SUPPLY)  wait_cnt <= wait_cnt + 1'b1;
        else                                   wait_cnt <= '0;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!pwr_req_en_o && reg_rdata_o == 5'b10000)); // R1

    AST_KICK_STARTS: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == PS_POWERED_DOWN && kick_evt && reg_rdata_o[3])
        |=> (pwr_req_en_o && reg_rdata_o[1])); // R3

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == PS_WAIT_SUPPLY) |-> (wait_cnt < WIN_W'(PWRON_TMO_CYC))); // R4

    AST_KICK_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[1] && !reg_wr_i) |=> reg_rdata_o[1]); // R4

    AST_PDOWN_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == PS_WAIT_SUPPLY && supply_good_i)
        |=> (!reg_rdata_o[4] && pwr_req_en_o)); // R5

    AST_PDOWN_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == PS_POWERED && reg_wr_i && reg_wdata_i[4]) |=> !pwr_req_en_o); // R6

endmodule

bind wkpwr_seq wkpwr_seq_chk #(.PWRON_TMO_CYC(PWRON_TMO_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .supply_good_i (supply_good_i),
    .pwr_req_en_o  (pwr_req_en_o),
    .fsm_state     (fsm_state),
    .kick_evt      (kick_evt)
);

// File: tb/wkpwr_seq_tb_top.sv
module wkpwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KMIN       = 8;
    localparam int TMO        = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kick_n = 1'b1, wake = 1'b0, sgood = 1'b0, apf = 1'b0, ext = 1'b0;
    logic       wr = 1'b0;
    logic [4:0] wdata = '0;
    logic [4:0] rdata;
    logic       preq, irq_n, irq_oe;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wkpwr_seq #(.KICK_MIN_CYC(KMIN), .PWRON_TMO_CYC(TMO)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .kick_n_i       (kick_n),
        .wake_match_i   (wake),
        .supply_good_i  (sgood),
        .above_pf_i     (apf),
        .ext_irq_pend_i (ext),
        .reg_wr_i       (wr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .pwr_req_en_o   (preq),
        .irq_n_o        (irq_n),
        .irq_oe_o       (irq_oe)
    );

    function automatic logic exp_irq_n(input logic [4:0] r, input logic e);
        return ~((r[0] & r[2]) | (r[1] & r[3]) | e);
    endfunction

    function automatic logic exp_flag(input logic cur, input logic w, input logic wb,
                                      input logic ev);
        return (w ? (cur & wb) : cur) | ev;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [4:0] v);
        wr = 1'b1; wdata = v;
        cyc(1);
        wr = 1'b0;
    endtask

    task automatic kick(input int len);
        kick_n = 1'b0;
        cyc(len);
        kick_n = 1'b1;
        cyc(6);
    endtask

    task automatic wake_pulse();
        wake = 1'b1;
        cyc(1);
        wake = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] m;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset values
        check("R1 pwr_req", preq, 0);
        check("R1 register", rdata, 5'b10000);
        check("R9 irq_oe low supply", irq_oe, 0);

        reg_write(5'b11000);               // kick enable only
        check("R7 enable write", rdata, 5'b11000);

        // R2 short pulse ignored
        kick(KMIN - 1);
        check("R2 short kick register", rdata, 5'b11000);
        check("R2 short kick pwr_req", preq, 0);

        // R3 disabled wake while down ignored
        wake_pulse();
        check("R3 disabled wake register", rdata, 5'b11000);
        check("R3 disabled wake pwr_req", preq, 0);

        // R2/R3 pulse of exactly the minimum width starts power-on
        kick(KMIN);
        check("R2 min kick flag", rdata, 5'b11010);
        check("R3 kick pwr_req", preq, 1);

        // R4 no supply: released, flag sticky, irq undriven
        cyc(TMO + 4);
        check("R4 timeout pwr_req", preq, 0);
        check("R4 sticky flag", rdata, 5'b11010);
        check("R9 irq_oe still low", irq_oe, 0);

        // R7 writing 1 to flags leaves them, enables take value
        reg_write(5'b11111);
        check("R7 write-one no set", rdata, 5'b11110);

        // R3 enabled wake asserts request next cycle
        wake_pulse();
        check("R3 wake pwr_req", preq, 1);
        check("R3 wake flag", rdata[0], 1);
        cyc(3);
        sgood = 1'b1; apf = 1'b1;
        cyc(2);
        check("R5 stays on", preq, 1);
        check("R5 pdown cleared", rdata, 5'b01111);
        check("R9 irq_oe", irq_oe, 1);
        check("R8 cause irq", irq_n, 0);

        // R7 clear flags, R8 irq follows
        reg_write(5'b01100);
        check("R7 clear flags", rdata, 5'b01100);
        check("R8 irq idle", irq_n, 1);
        ext = 1'b1; cyc(1);
        check("R8 external pending", irq_n, 0);
        ext = 1'b0;

        // R11 flags set while powered with enables off
        reg_write(5'b00000);
        wake_pulse();
        kick(KMIN + 2);
        check("R11 flags set unenabled", rdata, 5'b00011);
        check("R11 irq gated", irq_n, 1);
        reg_write(5'b00000);
        check("R7 clear both", rdata, 5'b00000);

        // Random phase while powered
        m = 5'b00000;
        for (int i = 0; i < 400; i++) begin
            logic       w, wk, e;
            logic [4:0] d;
            w  = 1'($urandom % 2);
            d  = {1'b0, 4'($urandom)};
            wk = ($urandom % 4) == 0;
            e  = ($urandom % 5) == 0;
            wr = w; wdata = d; wake = wk; ext = e;
            cyc(1);
            m[0] = exp_flag(m[0], w, d[0], wk);
            m[1] = exp_flag(m[1], w, d[1], 1'b0);
            if (w) begin m[2] = d[2]; m[3] = d[3]; end
            check("R7 random register", rdata, m);
            check("R8 random irq", irq_n, exp_irq_n(m, e));
            check("R5 random pwr_req held", preq, 1);
        end
        wr = 1'b0; wake = 1'b0; ext = 1'b0;

        // R6 power-down write releases next cycle
        reg_write(5'b10000);
        check("R6 release", preq, 0);
        check("R6 register", rdata, 5'b10000);

        // R10 supply still good: enabled kick re-asserts and clears pdown
        reg_write(5'b11000);
        kick(KMIN + 1);
        check("R10 re-request", preq, 1);
        check("R10 pdown cleared", rdata, 5'b01010);

        // R9 supply falls below power-fail
        apf = 1'b0; cyc(1);
        check("R9 irq released", irq_oe, 0);

        finish_run();
    end
endmodule